// File: doc/BRIEF.md
# Word FIFO with Byte Packing Engine

This block sits between a host that moves 32-bit words and a card-side channel that moves one byte at a time. It holds a 16-entry circular word FIFO. When the transfer runs from card to host, incoming bytes are gathered four at a time into little-endian words and pushed into the FIFO. When it runs from host to card, words are taken from the FIFO and sent out one byte at a time, least significant byte first. A byte counter fixes the size of the transfer.

Software writes a control strobe that carries an enable and a direction, together with a 16-bit length. The engine then counts bytes down to zero. It raises sticky end-of-transfer flags and drops its own enable once the counter is zero and the FIFO has drained. A live flag vector reports the FIFO fill thresholds for the active direction only.

Top module: `wfp_xfer_engine`

## Requirements
- R1: The FIFO keeps 16 words in arrival order. A push while it holds 16 words is dropped. A pop while it is empty changes nothing, and `host_rdata` reads 0 whenever the FIFO is empty.
- R2: In card-to-host direction (`ctrl_dir`=1), accepted bytes are packed so that the k-th byte of each group of four lands in word bits 8k+7:8k. A word is pushed on every fourth byte.
- R3: If the counter reaches zero with 1 to 3 bytes gathered, that partial word is pushed with its unused upper bytes zero.
- R4: `card_rx_ready` is low while the FIFO holds 16 words. Byte intake resumes once the host pops.
- R5: In host-to-card direction (`ctrl_dir`=0), bytes leave least significant first, and only while the counter is nonzero. A word is taken from the FIFO only after all four bytes of the previous word have been sent.
- R6: A `ctrl_wr` strobe with `ctrl_en`=1 loads the counter from `xfer_len` and sets `xfer_en`. The strobe also latches `ctrl_dir` (1 = card to host). A strobe with `ctrl_en`=0 clears `xfer_en` and leaves the counter as it was.
- R7: The counter drops by one for each byte moved. `bytes_left` shows it, and `words_left` equals (`bytes_left`+3)>>2.
- R8: `data_end` and `block_end` become 1 one cycle after the counter is zero while `xfer_en` is 1. They stay 1 until the next enabling strobe clears them.
- R9: `xfer_en` clears by itself one cycle after the counter is zero and the FIFO is empty.
- R10: `fifo_flags` bit positions are fixed. Even bits form the host-to-card group: 0 active, 2 level<=8, 4 level=16, 6 level=0, 8 level>0. Odd bits form the card-to-host group: 1 active, 3 level>=8, 5 level=16, 7 level=0, 9 level>0. "Active" means `xfer_en`. The group of the direction that is not selected reads 0.
- R11: In card-to-host direction `host_push` has no effect. In host-to-card direction `host_pop` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_en | input | 1 | Enable carried by the strobe |
| ctrl_dir | input | 1 | Direction carried by the strobe, 1 = card to host |
| xfer_len | input | 16 | Transfer length in bytes |
| host_push | input | 1 | Host pushes a word |
| host_wdata | input | 32 | Word pushed by the host |
| host_pop | input | 1 | Host pops a word |
| host_rdata | output | 32 | Head word of the FIFO, 0 when empty |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_byte | input | 8 | Byte offered by the card |
| card_rx_ready | output | 1 | Engine accepts the offered byte |
| card_tx_valid | output | 1 | Engine offers a byte to the card |
| card_tx_byte | output | 8 | Byte offered to the card |
| card_tx_ready | input | 1 | Card accepts the offered byte |
| xfer_en | output | 1 | Transfer enable, clears by itself |
| data_end | output | 1 | Sticky end-of-data flag |
| block_end | output | 1 | Sticky end-of-block flag |
| bytes_left | output | 16 | Remaining byte count |
| words_left | output | 15 | Remaining word count, rounded up |
| fifo_flags | output | 10 | FIFO status flags of the active direction |

## Verification
If the read pointer or the fill level is wrong, it shows up as a wrong head word on `host_rdata`, or as threshold flags that disagree with the number of words moved. Both are visible at the first pop or flag sample after the error. A packing lane index that is off shows up as bytes in the wrong place, in the very next word pushed or sent. A counter or enable fault shows up as `card_tx_valid` still offering bytes after the length is used up, or as `xfer_en` and `data_end` changing one or more cycles away from the expected edge.

// File: rtl/wfp_pkg.sv
package wfp_pkg;
  localparam int unsigned DEF_DEPTH  = 16;
  localparam int unsigned DEF_WORD_W = 32;
  localparam int unsigned DEF_BYTE_W = 8;
  localparam int unsigned DEF_LEN_W  = 16;

  localparam int unsigned FLG_N     = 10;
  localparam int unsigned F_TX_ACT  = 0;
  localparam int unsigned F_RX_ACT  = 1;
  localparam int unsigned F_TX_HE   = 2;
  localparam int unsigned F_RX_HF   = 3;
  localparam int unsigned F_TX_FULL = 4;
  localparam int unsigned F_RX_FULL = 5;
  localparam int unsigned F_TX_EMP  = 6;
  localparam int unsigned F_RX_EMP  = 7;
  localparam int unsigned F_TX_AV   = 8;
  localparam int unsigned F_RX_AV   = 9;

  typedef enum logic {
    DIR_TO_CARD = 1'b0,
    DIR_TO_HOST = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/wfp_ring.sv
module wfp_ring #(
  parameter int unsigned DEPTH  = wfp_pkg::DEF_DEPTH,
  parameter int unsigned WORD_W = wfp_pkg::DEF_WORD_W,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] wdata,
  input  logic              pop,
  output logic [WORD_W-1:0] rdata,
  output logic [LVL_W-1:0]  level
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d, wr_idx;
  logic [LVL_W-1:0]  level_q, level_d;
  logic              push_ok, pop_ok;

  always_comb begin
    push_ok  = push && (level_q != LVL_W'(DEPTH));
    pop_ok   = pop && (level_q != '0);
    wr_idx   = rd_ptr_q + level_q[PTR_W-1:0];
    rd_ptr_d = pop_ok ? rd_ptr_q + PTR_W'(1) : rd_ptr_q;
    level_d  = level_q;
    case ({push_ok, pop_ok})
      2'b10:   level_d = level_q + LVL_W'(1);
      2'b01:   level_d = level_q - LVL_W'(1);
      default: level_d = level_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  assign rdata = (level_q != '0) ? mem[rd_ptr_q] : '0;
  assign level = level_q;
endmodule

// File: rtl/wfp_rx_pack.sv
module wfp_rx_pack #(
  parameter int unsigned WORD_W = wfp_pkg::DEF_WORD_W,
  parameter int unsigned BYTE_W = wfp_pkg::DEF_BYTE_W,
  localparam int unsigned LANES  = WORD_W / BYTE_W,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fire,
  input  logic              last,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              push,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [LANE_W-1:0] idx_q, idx_d;

  always_comb begin
    word  = acc_q | (WORD_W'(byte_in) << (idx_q * BYTE_W));
    push  = fire && ((idx_q == LANE_W'(LANES - 1)) || last);
    acc_d = acc_q;
    idx_d = idx_q;
    if (clear || push) begin
      acc_d = '0;
      idx_d = '0;
    end else if (fire) begin
      acc_d = word;
      idx_d = idx_q + LANE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= '0;
    end else begin
      acc_q <= acc_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/wfp_tx_unpack.sv
module wfp_tx_unpack #(
  parameter int unsigned WORD_W = wfp_pkg::DEF_WORD_W,
  parameter int unsigned BYTE_W = wfp_pkg::DEF_BYTE_W,
  localparam int unsigned LANES  = WORD_W / BYTE_W,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              active,
  input  logic              src_avail,
  input  logic [WORD_W-1:0] src_word,
  input  logic              card_ready,
  output logic              src_pop,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_out,
  output logic              fire
);
  logic [WORD_W-1:0] hold_q, hold_d;
  logic [LANE_W-1:0] idx_q, idx_d;
  logic              have_q, have_d;

  always_comb begin
    src_pop    = active && !have_q && src_avail;
    byte_valid = active && have_q;
    fire       = byte_valid && card_ready;
    byte_out   = hold_q[idx_q*BYTE_W +: BYTE_W];
    hold_d     = hold_q;
    idx_d      = idx_q;
    have_d     = have_q;
    if (clear) begin
      idx_d  = '0;
      have_d = 1'b0;
    end else if (src_pop) begin
      hold_d = src_word;
      idx_d  = '0;
      have_d = 1'b1;
    end else if (fire) begin
      idx_d = idx_q + LANE_W'(1);
      if (idx_q == LANE_W'(LANES - 1)) have_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      idx_q  <= '0;
      have_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      idx_q  <= idx_d;
      have_q <= have_d;
    end
  end
endmodule

// File: rtl/wfp_xfer_engine.sv
module wfp_xfer_engine #(
  parameter int unsigned DEPTH  = wfp_pkg::DEF_DEPTH,
  parameter int unsigned WORD_W = wfp_pkg::DEF_WORD_W,
  parameter int unsigned BYTE_W = wfp_pkg::DEF_BYTE_W,
  parameter int unsigned LEN_W  = wfp_pkg::DEF_LEN_W,
  localparam int unsigned LANES  = WORD_W / BYTE_W,
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned LVL_W  = $clog2(DEPTH) + 1,
  localparam int unsigned WL_W   = LEN_W + 1 - LANE_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ctrl_wr,
  input  logic                         ctrl_en,
  input  logic                         ctrl_dir,
  input  logic [LEN_W-1:0]             xfer_len,
  input  logic                         host_push,
  input  logic [WORD_W-1:0]            host_wdata,
  input  logic                         host_pop,
  output logic [WORD_W-1:0]            host_rdata,
  input  logic                         card_rx_valid,
  input  logic [BYTE_W-1:0]            card_rx_byte,
  output logic                         card_rx_ready,
  output logic                         card_tx_valid,
  output logic [BYTE_W-1:0]            card_tx_byte,
  input  logic                         card_tx_ready,
  output logic                         xfer_en,
  output logic                         data_end,
  output logic                         block_end,
  output logic [LEN_W-1:0]             bytes_left,
  output logic [WL_W-1:0]              words_left,
  output logic [wfp_pkg::FLG_N-1:0]    fifo_flags
);
  import wfp_pkg::*;

  logic              en_q, en_d, end_q, end_d;
  xfer_dir_e         dir_q, dir_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [LEN_W:0]    wl_sum;
  logic              load, cnt_nz, rx_fire, tx_fire, tx_active, tx_pop;
  logic              fifo_push, fifo_pop, fifo_full, fifo_nz;
  logic [WORD_W-1:0] fifo_wdata, fifo_rdata, pk_word;
  logic              pk_push;
  logic [LVL_W-1:0]  fifo_level;
  logic [FLG_N-1:0]  flg_all, flg_mask;

  assign load      = ctrl_wr && ctrl_en;
  assign cnt_nz    = (cnt_q != '0);
  assign fifo_full = (fifo_level == LVL_W'(DEPTH));
  assign fifo_nz   = (fifo_level != '0);

  // card-side acceptance and host-side routing
  assign card_rx_ready = en_q && (dir_q == DIR_TO_HOST) && cnt_nz && !fifo_full;
  assign rx_fire       = card_rx_ready && card_rx_valid;
  assign tx_active     = en_q && (dir_q == DIR_TO_CARD) && cnt_nz;
  assign fifo_push     = (dir_q == DIR_TO_HOST) ? pk_push : host_push;
  assign fifo_wdata    = (dir_q == DIR_TO_HOST) ? pk_word : host_wdata;
  assign fifo_pop      = (dir_q == DIR_TO_HOST) ? host_pop : tx_pop;

  wfp_ring #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(fifo_wdata),
    .pop(fifo_pop), .rdata(fifo_rdata), .level(fifo_level)
  );

  wfp_rx_pack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(ctrl_wr), .fire(rx_fire),
    .last(cnt_q == LEN_W'(1)), .byte_in(card_rx_byte),
    .push(pk_push), .word(pk_word)
  );

  wfp_tx_unpack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .clear(ctrl_wr), .active(tx_active),
    .src_avail(fifo_nz), .src_word(fifo_rdata), .card_ready(card_tx_ready),
    .src_pop(tx_pop), .byte_valid(card_tx_valid), .byte_out(card_tx_byte),
    .fire(tx_fire)
  );

  // control next state
  always_comb begin
    en_d  = en_q;
    dir_d = dir_q;
    cnt_d = cnt_q;
    end_d = end_q;
    if (ctrl_wr) begin
      en_d  = ctrl_en;
      dir_d = xfer_dir_e'(ctrl_dir);
    end else if (en_q && !cnt_nz && !fifo_nz) begin
      en_d = 1'b0;
    end
    if (load) cnt_d = xfer_len;
    else if (rx_fire || tx_fire) cnt_d = cnt_q - LEN_W'(1);
    if (load) end_d = 1'b0;
    else if (en_q && !cnt_nz) end_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      dir_q <= DIR_TO_CARD;
      cnt_q <= '0;
      end_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      dir_q <= dir_d;
      cnt_q <= cnt_d;
      end_q <= end_d;
    end
  end

  // flag vector: even bits host-to-card, odd bits card-to-host
  always_comb begin
    flg_all            = '0;
    flg_all[F_TX_ACT]  = en_q;
    flg_all[F_RX_ACT]  = en_q;
    flg_all[F_TX_HE]   = (fifo_level <= LVL_W'(DEPTH / 2));
    flg_all[F_RX_HF]   = (fifo_level >= LVL_W'(DEPTH / 2));
    flg_all[F_TX_FULL] = fifo_full;
    flg_all[F_RX_FULL] = fifo_full;
    flg_all[F_TX_EMP]  = !fifo_nz;
    flg_all[F_RX_EMP]  = !fifo_nz;
    flg_all[F_TX_AV]   = fifo_nz;
    flg_all[F_RX_AV]   = fifo_nz;
  end

  for (genvar g = 0; g < FLG_N; g++) begin : g_mask
    assign flg_mask[g] = ((g % 2) == 1) ? (dir_q == DIR_TO_HOST) : (dir_q == DIR_TO_CARD);
  end

  assign wl_sum     = {1'b0, cnt_q} + (LEN_W+1)'(LANES - 1);
  assign words_left = wl_sum[LEN_W:LANE_W];
  assign fifo_flags = flg_all & flg_mask;
  assign host_rdata = fifo_rdata;
  assign bytes_left = cnt_q;
  assign xfer_en    = en_q;
  assign data_end   = end_q;
  assign block_end  = end_q;
endmodule

// File: rtl/wfp_xfer_chk.sv
module wfp_xfer_chk #(
  parameter int unsigned DEPTH = wfp_pkg::DEF_DEPTH,
  parameter int unsigned LEN_W = wfp_pkg::DEF_LEN_W,
  localparam int unsigned LVL_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr,
  input logic             dir_q,
  input logic [LVL_W-1:0] level,
  input logic             fifo_push,
  input logic             fifo_pop,
  input logic             card_rx_ready,
  input logic             card_tx_valid,
  input logic             rx_fire,
  input logic             tx_fire,
  input logic             xfer_en,
  input logic             data_end,
  input logic [LEN_W-1:0] bytes_left,
  input logic [9:0]       fifo_flags
);
  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  // R1
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_W'(DEPTH) && fifo_push && !fifo_pop) |=> level == LVL_W'(DEPTH));

  // R4
  rx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_rx_ready |-> level != LVL_W'(DEPTH));

  // R5
  tx_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_tx_valid |-> bytes_left != '0);

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_fire || tx_fire) && !ctrl_wr) |=> bytes_left == $past(bytes_left) - LEN_W'(1));

  // R8
  end_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_end) |-> ($past(xfer_en) && $past(bytes_left) == '0));

  // R9
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && bytes_left == '0 && level == '0 && !ctrl_wr) |=> !xfer_en);

  // R10
  group_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_q |-> (fifo_flags & 10'h155) == 10'h000);
endmodule

bind wfp_xfer_engine wfp_xfer_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .dir_q(dir_q), .level(fifo_level),
  .fifo_push(fifo_push), .fifo_pop(fifo_pop), .card_rx_ready(card_rx_ready),
  .card_tx_valid(card_tx_valid), .rx_fire(rx_fire), .tx_fire(tx_fire),
  .xfer_en(xfer_en), .data_end(data_end), .bytes_left(bytes_left),
  .fifo_flags(fifo_flags)
);

// File: tb/wfp_xfer_engine_bench.sv
`timescale 1ns/1ps
module wfp_xfer_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_wr, ctrl_en, ctrl_dir;
  logic [15:0] xfer_len;
  logic        host_push, host_pop;
  logic [31:0] host_wdata, host_rdata;
  logic        card_rx_valid, card_rx_ready;
  logic [7:0]  card_rx_byte, card_tx_byte;
  logic        card_tx_valid, card_tx_ready;
  logic        xfer_en, data_end, block_end;
  logic [15:0] bytes_left;
  logic [14:0] words_left;
  logic [9:0]  fifo_flags;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0]  bb [0:127];
  logic [31:0] ww [0:31];
  logic [7:0]  got [0:127];
  int          n_got;
  int unsigned seed_dummy;

  always #5 clk = ~clk;

  wfp_xfer_engine u_wfp_xfer_engine (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
    .ctrl_dir(ctrl_dir), .xfer_len(xfer_len), .host_push(host_push),
    .host_wdata(host_wdata), .host_pop(host_pop), .host_rdata(host_rdata),
    .card_rx_valid(card_rx_valid), .card_rx_byte(card_rx_byte),
    .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
    .card_tx_byte(card_tx_byte), .card_tx_ready(card_tx_ready),
    .xfer_en(xfer_en), .data_end(data_end), .block_end(block_end),
    .bytes_left(bytes_left), .words_left(words_left), .fifo_flags(fifo_flags)
  );

  function automatic logic [9:0] exp_flags(input int lvl, input bit dir, input bit en);
    logic [9:0] f;
    f = '0;
    f[0] = en;          f[1] = en;
    f[2] = (lvl <= 8);  f[3] = (lvl >= 8);
    f[4] = (lvl == 16); f[5] = (lvl == 16);
    f[6] = (lvl == 0);  f[7] = (lvl == 0);
    f[8] = (lvl > 0);   f[9] = (lvl > 0);
    return f & (dir ? 10'h2AA : 10'h155);
  endfunction

  function automatic logic [31:0] pack_word(input int j, input int len);
    logic [31:0] w;
    w = '0;
    for (int k = 0; k < 4; k++)
      if (4*j + k < len) w[8*k +: 8] = bb[4*j + k];
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic prog(input bit en, input bit dir, input logic [15:0] len);
    ctrl_wr = 1'b1; ctrl_en = en; ctrl_dir = dir; xfer_len = len;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    card_rx_valid = 1'b1; card_rx_byte = b;
    #1;
    while (!card_rx_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    card_rx_valid = 1'b0;
  endtask

  task automatic hpop(output logic [31:0] w);
    w = host_rdata;
    host_pop = 1'b1;
    @(negedge clk);
    host_pop = 1'b0;
  endtask

  task automatic hpush(input logic [31:0] w);
    host_push = 1'b1; host_wdata = w;
    @(negedge clk);
    host_push = 1'b0;
  endtask

  task automatic tx_collect(input int n, input bit rnd);
    int guard;
    n_got = 0; guard = 0;
    while (n_got < n && guard < 2000) begin
      card_tx_ready = rnd ? 1'($urandom % 2) : 1'b1;
      #1;
      if (card_tx_valid && card_tx_ready) begin
        got[n_got] = card_tx_byte;
        n_got++;
      end
      @(negedge clk);
      guard++;
    end
    card_tx_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] w;
    int lens [5];
    seed_dummy = $urandom(32'd4242);
    rst_n = 1'b0; ctrl_wr = 0; ctrl_en = 0; ctrl_dir = 0; xfer_len = '0;
    host_push = 0; host_pop = 0; host_wdata = '0;
    card_rx_valid = 0; card_rx_byte = '0; card_tx_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R10 reset flags", 32'(fifo_flags), 32'(exp_flags(0, 0, 0)));
    chk("R6 reset enable", 32'(xfer_en), 32'd0);
    chk("R7 reset count", 32'(bytes_left), 32'd0);
    chk("R8 reset end", 32'(data_end), 32'd0);
    chk("R1 reset head", host_rdata, 32'd0);

    // card-to-host transfers: full words and partial tails
    lens[0] = 8; lens[1] = 5; lens[2] = 1; lens[3] = 11; lens[4] = 1 + ($urandom % 40);
    foreach (lens[t]) begin
      int len, nw;
      len = lens[t];
      nw = (len + 3) / 4;
      prog(1'b1, 1'b1, 16'(len));
      chk("R6 load count", 32'(bytes_left), 32'(len));
      chk("R6 enable set", 32'(xfer_en), 32'd1);
      chk("R8 end cleared by load", 32'(data_end), 32'd0);
      chk("R10 rx flags idle", 32'(fifo_flags), 32'(exp_flags(0, 1, 1)));
      for (int i = 0; i < len; i++) begin
        bb[i] = 8'($urandom);
        repeat ($urandom % 3) @(negedge clk);
        rx_send(bb[i]);
        if (i == 0) begin
          chk("R7 count step", 32'(bytes_left), 32'(len - 1));
          chk("R7 word count", 32'(words_left), 32'((len + 2) / 4));
        end
      end
      repeat (2) @(negedge clk);
      chk("R8 data end", 32'(data_end), 32'd1);
      chk("R8 block end", 32'(block_end), 32'd1);
      chk("R9 held while FIFO holds data", 32'(xfer_en), 32'd1);
      chk("R10 rx flags filled", 32'(fifo_flags), 32'(exp_flags(nw, 1, 1)));
      for (int j = 0; j < nw; j++) begin
        hpop(w);
        chk((4*j + 4 > len) ? "R3 partial word" : "R2 packed word", w, pack_word(j, len));
      end
      repeat (2) @(negedge clk);
      chk("R9 auto clear", 32'(xfer_en), 32'd0);
    end

    // stall while full
    prog(1'b1, 1'b1, 16'd72);
    for (int i = 0; i < 64; i++) begin
      bb[i] = 8'($urandom);
      rx_send(bb[i]);
    end
    card_rx_valid = 1'b1; card_rx_byte = 8'hAA;
    #1;
    chk("R4 ready low when full", 32'(card_rx_ready), 32'd0);
    chk("R10 rx full flags", 32'(fifo_flags), 32'(exp_flags(16, 1, 1)));
    repeat (3) @(negedge clk);
    #1;
    chk("R4 still stalled", 32'(card_rx_ready), 32'd0);
    chk("R7 count frozen", 32'(bytes_left), 32'd8);
    @(negedge clk);
    card_rx_valid = 1'b0;
    for (int j = 0; j < 16; j++) begin
      hpop(w);
      chk("R2 stalled word", w, pack_word(j, 72));
    end
    for (int i = 64; i < 72; i++) begin
      bb[i] = 8'($urandom);
      rx_send(bb[i]);
    end
    for (int j = 16; j < 18; j++) begin
      hpop(w);
      chk("R4 resumed word", w, pack_word(j, 72));
    end

    // host-to-card: 3 words, 10 bytes
    prog(1'b0, 1'b0, 16'd0);
    for (int j = 0; j < 3; j++) begin
      ww[j] = $urandom;
      hpush(ww[j]);
    end
    hpop(w);
    chk("R11 pop ignored head", host_rdata, ww[0]);
    chk("R11 pop ignored level", 32'(fifo_flags), 32'(exp_flags(3, 0, 0)));
    prog(1'b1, 1'b0, 16'd10);
    tx_collect(10, 1'b1);
    chk("R5 byte count", 32'(n_got), 32'd10);
    for (int i = 0; i < 10; i++)
      chk("R5 byte order", 32'(got[i]), 32'(ww[i/4][8*(i%4) +: 8]));
    #1;
    chk("R5 no byte after count", 32'(card_tx_valid), 32'd0);
    repeat (2) @(negedge clk);
    chk("R8 tx end", 32'(data_end), 32'd1);
    chk("R9 tx auto clear", 32'(xfer_en), 32'd0);

    // push past full, then drain
    prog(1'b0, 1'b0, 16'd0);
    for (int j = 0; j < 17; j++) begin
      ww[j] = $urandom;
      hpush(ww[j]);
    end
    chk("R10 tx full flags", 32'(fifo_flags), 32'(exp_flags(16, 0, 0)));
    chk("R1 head kept", host_rdata, ww[0]);
    prog(1'b1, 1'b0, 16'd64);
    tx_collect(64, 1'b0);
    for (int i = 0; i < 64; i++)
      if (got[i] !== ww[i/4][8*(i%4) +: 8])
        chk("R1 order after overflow", 32'(got[i]), 32'(ww[i/4][8*(i%4) +: 8]));
    chk("R1 seventeenth word dropped", 32'(n_got), 32'd64);
    repeat (2) @(negedge clk);
    chk("R1 drained", 32'(fifo_flags), 32'(exp_flags(0, 0, 0)));

    // empty pop and ignored push in card-to-host direction
    prog(1'b0, 1'b1, 16'd0);
    hpop(w);
    chk("R1 empty pop", w, 32'd0);
    hpush(32'hDEADBEEF);
    chk("R11 push ignored", host_rdata, 32'd0);
    chk("R11 push ignored flags", 32'(fifo_flags), 32'(exp_flags(0, 1, 0)));

    // zero length
    prog(1'b1, 1'b1, 16'd0);
    repeat (2) @(negedge clk);
    chk("R8 zero length end", 32'(data_end), 32'd1);
    chk("R9 zero length clear", 32'(xfer_en), 32'd0);

    summary();
    $finish;
  end
endmodule